// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time in packed BCD: seconds, minutes, hours, weekday, date, month and year, plus a century flag. A tick input drives it. The tick normally pulses once per second, and a parameter can divide a faster tick down to one second. Date rollover follows month lengths and leap years. The hour byte can hold either a 24-hour or a 12-hour value with an AM/PM bit.

A host reaches the block through a byte-wide port. A load strobe sets an internal pointer from the address input. Each read or write strobe then touches the register under the pointer and moves the pointer forward by one. A single burst from address 0 therefore moves all seven time bytes. A read burst returns a copy of the time taken at the load, so a tick in the middle of the burst cannot split the value. A control byte starts and stops the oscillator. A sticky status bit reports that the held time cannot be trusted, and it stays set until the host writes new time.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hour 0x00, weekday 0x01, date 0x01, month 0x01 and year 0x00. The control byte reads 0x80 and the status byte reads 0x80.
- R2: A cycle with `ptr_load_i` high loads the pointer from `addr_i`. Each `rd_i` or `wr_i` cycle without a load accesses the register under the pointer and then adds one to the pointer, wrapping from 0xF to 0x0. The map is: 0x0 seconds, 0x1 minutes, 0x2 hour, 0x3 weekday, 0x4 date, 0x5 month, 0x6 year, 0xE control, 0xF status. Every other address reads 0x00 and ignores writes.
- R3: Time bytes read in a burst are the values held at the load. Seconds that elapse after the load do not appear in the burst; a fresh load shows them.
- R4: Control bit 7 set stops the oscillator, and while it is set ticks have no effect on the time. It is set at reset. Control bits 6:0 read 0.
- R5: Status bit 7 is set at reset and in the cycle after the control stop bit is seen set. It is cleared only by a write to the seconds byte while the oscillator runs. Writes to the status byte have no effect. Status bits 6:0 read 0.
- R6: While the oscillator runs, the seconds advance on every TICK_DIV-th tick. A write to the seconds byte restarts the tick count, so exactly TICK_DIV ticks after that write advance the time by one second.
- R7: Seconds count 00 to 59 and minutes count 00 to 59 in BCD. Going from 59 to 00 carries into the next field.
- R8: With hour bit 6 clear, bits 5:0 hold a BCD hour from 00 to 23. The step from 23 to 00 advances the date and the weekday.
- R9: With hour bit 6 set, bit 5 is PM and bits 4:0 hold a BCD hour from 01 to 12. The step from 11 to 12 flips PM, the step from 12 to 01 keeps it, and only the 11 PM to 12 AM step advances the date.
- R10: The date wraps to 01 after 31, 30 or 28/29 according to the BCD month. February has 29 days when the BCD year is divisible by 4.
- R11: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and flips the century flag in month bit 7.
- R12: The weekday counts 1 to 7 and wraps to 1 whenever the date advances.
- R13: Writes keep only the meaningful bits. Seconds, minutes and hour store bits 6:0, weekday stores bits 2:0, date stores bits 5:0, month stores bits 7 and 4:0, and year stores all eight bits. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| ptr_load_i | input | 1 | Load the pointer from addr_i and capture the time copy |
| addr_i | input | 4 | Start address of a burst |
| rd_i | input | 1 | Read strobe; advances the pointer |
| wr_i | input | 1 | Write strobe; writes wdata_i and advances the pointer |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register under the pointer |

## Verification
The assertions assume the host writes only valid BCD into seconds and hours, the fields whose ranges they check. They also assume at most one of load, read and write per cycle, and a tick input no wider than one cycle. The bench drives a single strobe for one cycle at a time. Its one out-of-range write goes to the weekday, date and month bytes, and a valid time is written before any tick follows it. No tick is driven in a cycle that also writes a time byte, so each second boundary lands where the bench predicts it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NUM_TIME = 7;

  localparam logic [ADDR_W-1:0] A_SEC  = 4'h0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'h1;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'h2;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'h3;
  localparam logic [ADDR_W-1:0] A_DATE = 4'h4;
  localparam logic [ADDR_W-1:0] A_MON  = 4'h5;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'h6;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'hE;
  localparam logic [ADDR_W-1:0] A_STAT = 4'hF;

  typedef struct packed {
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] wday;
    logic [DATA_W-1:0] date;
    logic [DATA_W-1:0] mon;
    logic [DATA_W-1:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                     wday: 8'h01, date: 8'h01, mon: 8'h01,
                                     year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] == 4'h9) return {b[7:4] + 4'h1, 4'h0};
    return {b[7:4], b[3:0] + 4'h1};
  endfunction

  // BCD year divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] last_date(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_phase.sv
module rtc_tick_phase #(
  parameter int TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic adv_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] phase_q;
  logic          cnt_en;

  assign cnt_en = tick_i & run_i & ~hold_i & ~clr_i;
  assign adv_o  = cnt_en & (phase_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_q <= '0;
    else if (clr_i)      phase_q <= '0;
    else if (cnt_en)     phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  p_phase_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= LAST);
  p_phase_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rtc_time_t         time_o
);
  rtc_time_t time_q, nxt;
  logic      wr_time;

  assign wr_time = wr_i && (waddr_i < ADDR_W'(NUM_TIME));
  assign time_o  = time_q;

  // one-second carry chain
  always_comb begin
    logic       c_min, c_hr, c_day, c_mon, c_yr, pm;
    logic [7:0] h8, ld;
    logic [2:0] wd;
    nxt   = time_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    pm    = time_q.hour[5];
    h8    = 8'h00;
    wd    = time_q.wday[2:0];
    ld    = last_date(time_q.mon[4:0], time_q.year);

    if (time_q.sec == 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
    else nxt.sec = bcd_inc(time_q.sec);

    if (c_min) begin
      if (time_q.min == 8'h59) begin nxt.min = 8'h00; c_hr = 1'b1; end
      else nxt.min = bcd_inc(time_q.min);
    end

    if (c_hr) begin
      if (time_q.hour[6]) begin
        h8 = bcd_inc({3'b000, time_q.hour[4:0]});
        if (time_q.hour[4:0] == 5'h11) begin
          nxt.hour = {2'b01, ~pm, 5'h12};
          c_day    = pm;
        end else if (time_q.hour[4:0] == 5'h12) nxt.hour = {2'b01, pm, 5'h01};
        else nxt.hour = {2'b01, pm, h8[4:0]};
      end else begin
        h8 = bcd_inc({2'b00, time_q.hour[5:0]});
        if (time_q.hour[5:0] == 6'h23) begin nxt.hour = 8'h00; c_day = 1'b1; end
        else nxt.hour = {2'b00, h8[5:0]};
      end
    end

    if (c_day) begin
      nxt.wday = (wd == 3'd7) ? 8'h01 : {5'b0, wd + 3'd1};
      if (time_q.date >= ld) begin nxt.date = 8'h01; c_mon = 1'b1; end
      else nxt.date = bcd_inc(time_q.date);
    end

    if (c_mon) begin
      h8 = bcd_inc({3'b000, time_q.mon[4:0]});
      if (time_q.mon[4:0] == 5'h12) begin
        nxt.mon = {time_q.mon[7], 2'b00, 5'h01};
        c_yr    = 1'b1;
      end else nxt.mon = {time_q.mon[7], 2'b00, h8[4:0]};
    end

    if (c_yr) begin
      if (time_q.year == 8'h99) begin
        nxt.year   = 8'h00;
        nxt.mon[7] = ~time_q.mon[7];
      end else nxt.year = bcd_inc(time_q.year);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= TIME_RST;
    else if (wr_time) begin
      case (waddr_i)
        A_SEC:   time_q.sec  <= {1'b0, wdata_i[6:0]};
        A_MIN:   time_q.min  <= {1'b0, wdata_i[6:0]};
        A_HOUR:  time_q.hour <= {1'b0, wdata_i[6:0]};
        A_WDAY:  time_q.wday <= {5'b0, wdata_i[2:0]};
        A_DATE:  time_q.date <= {2'b0, wdata_i[5:0]};
        A_MON:   time_q.mon  <= {wdata_i[7], 2'b0, wdata_i[4:0]};
        default: time_q.year <= wdata_i;
      endcase
    end else if (adv_i) time_q <= nxt;
  end

  p_sec_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_q.sec <= 8'h59);
  p_sec_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_time && time_q.sec == 8'h59) |=> time_q.sec == 8'h00);
  p_hour24_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_q.hour[6] |-> time_q.hour[5:0] <= 6'h23);
  p_pm_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_time && time_q.hour[6] && time_q.hour[4:0] == 5'h11 &&
     time_q.min == 8'h59 && time_q.sec == 8'h59)
    |=> time_q.hour[5] != $past(time_q.hour[5]));
  p_wday_nonzero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_time) |=> time_q.wday != 8'h00);
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              stop_bit_i,
  input  rtc_time_t         live_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              stop_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] ptr_q;
  rtc_time_t         snap_q;
  logic              stop_q, osf_q, acc;

  assign acc     = (rd_i | wr_i) & ~load_i;
  assign wr_en_o = wr_i & ~load_i;
  assign ptr_o   = ptr_q;
  assign stop_o  = stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      snap_q <= TIME_RST;
    end else if (load_i) begin
      ptr_q  <= addr_i;
      snap_q <= live_i;
    end else if (acc) ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b1;
      osf_q  <= 1'b1;
    end else begin
      if (wr_en_o && ptr_q == A_CTRL) stop_q <= stop_bit_i;
      // fault stays until a seconds write lands with the oscillator running
      if (stop_q) osf_q <= 1'b1;
      else if (wr_en_o && ptr_q == A_SEC) osf_q <= 1'b0;
    end
  end

  always_comb begin
    case (ptr_q)
      A_SEC:   rdata_o = snap_q.sec;
      A_MIN:   rdata_o = snap_q.min;
      A_HOUR:  rdata_o = snap_q.hour;
      A_WDAY:  rdata_o = snap_q.wday;
      A_DATE:  rdata_o = snap_q.date;
      A_MON:   rdata_o = snap_q.mon;
      A_YEAR:  rdata_o = snap_q.year;
      A_CTRL:  rdata_o = {stop_q, 7'b0};
      A_STAT:  rdata_o = {osf_q, 7'b0};
      default: rdata_o = '0;
    endcase
  end

  p_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> ptr_q == $past(ptr_q) + 4'd1);
  p_snap_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(snap_q));
  p_osf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |=> osf_q);
  p_osf_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osf_q) |-> $past(wr_en_o && ptr_q == A_SEC && !stop_q));
endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ptr_load_i,
  input  logic [3:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  rtc_time_t         time_w;
  logic              wr_en_w, stop_w, adv_w, hold_w, clr_w;
  logic [ADDR_W-1:0] ptr_w;

  assign hold_w = wr_en_w && (ptr_w < ADDR_W'(NUM_TIME));
  assign clr_w  = wr_en_w && (ptr_w == A_SEC);

  rtc_reg_port u_port (
    .clk_i, .rst_ni,
    .load_i     (ptr_load_i),
    .addr_i,
    .rd_i,
    .wr_i,
    .stop_bit_i (wdata_i[7]),
    .live_i     (time_w),
    .wr_en_o    (wr_en_w),
    .ptr_o      (ptr_w),
    .stop_o     (stop_w),
    .rdata_o
  );

  rtc_tick_phase #(.TICK_DIV(TICK_DIV)) u_phase (
    .clk_i, .rst_ni,
    .tick_i,
    .run_i  (~stop_w),
    .hold_i (hold_w),
    .clr_i  (clr_w),
    .adv_o  (adv_w)
  );

  rtc_time_core u_core (
    .clk_i, .rst_ni,
    .adv_i   (adv_w),
    .wr_i    (wr_en_w),
    .waddr_i (ptr_w),
    .wdata_i,
    .time_o  (time_w)
  );

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_w && !hold_w) |=> $stable(time_w));
endmodule

// File: tb/bcd_rtc_regfile_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_regfile_tb_top;
  localparam int DIV = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic       ptr_load_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [7:0] tm [0:6];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bcd_rtc_regfile #(.TICK_DIV(DIV)) dut_i (.*);

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [3:0] a);
    @(negedge clk_i); ptr_load_i = 1'b1; addr_i = a;
    @(negedge clk_i); ptr_load_i = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] d);
    d = rdata_o; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    load(a); wbyte(d);
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    load(a); rbyte(d);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
    load(4'h0);
    wbyte(s); wbyte(m); wbyte(h); wbyte(w); wbyte(d); wbyte(mo); wbyte(y);
  endtask

  task automatic read_time();
    load(4'h0);
    for (int i = 0; i < 7; i++) rbyte(tm[i]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_time();
    check("R1 sec", tm[0], 8'h00); check("R1 min", tm[1], 8'h00);
    check("R1 hour", tm[2], 8'h00); check("R1 wday", tm[3], 8'h01);
    check("R1 date", tm[4], 8'h01); check("R1 mon", tm[5], 8'h01);
    check("R1 year", tm[6], 8'h00);
    rreg(4'hE, v); check("R1 ctrl", v, 8'h80);
    rreg(4'hF, v); check("R1 status", v, 8'h80);
  endtask

  task automatic t_stopped_ticks();
    logic [7:0] v;
    ticks(3 * DIV);
    rreg(4'h0, v); check("R4 ticks ignored while stopped", v, 8'h00);
  endtask

  task automatic t_fault_flag();
    logic [7:0] v;
    wreg(4'hE, 8'h00);
    rreg(4'hE, v); check("R4 ctrl cleared", v, 8'h00);
    rreg(4'hF, v); check("R5 fault kept before time write", v, 8'h80);
    wreg(4'hF, 8'h00);
    rreg(4'hF, v); check("R5 status write ignored", v, 8'h80);
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    rreg(4'hF, v); check("R5 fault cleared by time write", v, 8'h00);
  endtask

  task automatic t_phase_and_rollover();
    logic [7:0] v;
    ticks(DIV - 1);
    rreg(4'h0, v); check("R6 no advance before last tick", v, 8'h58);
    ticks(1);
    rreg(4'h0, v); check("R6 advance on last tick", v, 8'h59);
    ticks(DIV);
    read_time();
    check("R7 sec wrap", tm[0], 8'h00); check("R7 min wrap", tm[1], 8'h00);
    check("R8 hour 23->00", tm[2], 8'h00); check("R12 wday 7->1", tm[3], 8'h01);
    check("R10 feb28 non-leap", tm[4], 8'h01); check("R10 month to 03", tm[5], 8'h03);
    check("R11 year kept", tm[6], 8'h23);
    ticks(2);
    wreg(4'h0, 8'h30);
    ticks(DIV - 1);
    rreg(4'h0, v); check("R6 phase restarted by write", v, 8'h30);
    ticks(1);
    rreg(4'h0, v); check("R6 one second after write", v, 8'h31);
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    ticks(DIV); read_time();
    check("R10 leap feb28->29", tm[4], 8'h29); check("R10 leap month kept", tm[5], 8'h02);
    check("R12 wday step", tm[3], 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    ticks(DIV); read_time();
    check("R10 feb29->01", tm[4], 8'h01); check("R10 to march", tm[5], 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
    ticks(DIV); read_time();
    check("R10 apr30->01", tm[4], 8'h01); check("R10 to may", tm[5], 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h05, 8'h25);
    ticks(DIV); read_time();
    check("R10 may30->31", tm[4], 8'h31);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    ticks(DIV); read_time();
    check("R11 year 99->00", tm[6], 8'h00); check("R11 century set, month 01", tm[5], 8'h81);
    check("R11 date 01", tm[4], 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h41);
    ticks(DIV); read_time();
    check("R11 year 41->42", tm[6], 8'h42); check("R11 no century change", tm[5], 8'h01);
  endtask

  task automatic t_twelve_hour();
    set_time(8'h59, 8'h59, 8'h51, 8'h02, 8'h05, 8'h06, 8'h30);
    ticks(DIV); read_time();
    check("R9 11AM->12PM", tm[2], 8'h72); check("R9 no date step at noon", tm[4], 8'h05);
    set_time(8'h59, 8'h59, 8'h71, 8'h02, 8'h05, 8'h06, 8'h30);
    ticks(DIV); read_time();
    check("R9 11PM->12AM", tm[2], 8'h52); check("R9 date step at midnight", tm[4], 8'h06);
    check("R12 wday at midnight", tm[3], 8'h03);
    set_time(8'h59, 8'h59, 8'h52, 8'h02, 8'h05, 8'h06, 8'h30);
    ticks(DIV); read_time();
    check("R9 12AM->1AM", tm[2], 8'h41);
    set_time(8'h59, 8'h59, 8'h69, 8'h02, 8'h05, 8'h06, 8'h30);
    ticks(DIV); read_time();
    check("R9 9PM->10PM", tm[2], 8'h70);
  endtask

  task automatic t_snapshot();
    set_time(8'h59, 8'h59, 8'h05, 8'h01, 8'h10, 8'h07, 8'h30);
    load(4'h0);
    ticks(DIV);
    for (int i = 0; i < 3; i++) rbyte(tm[i]);
    check("R3 snap sec", tm[0], 8'h59); check("R3 snap min", tm[1], 8'h59);
    check("R3 snap hour", tm[2], 8'h05);
    read_time();
    check("R3 reload sec", tm[0], 8'h00); check("R3 reload hour", tm[2], 8'h06);
  endtask

  task automatic t_masks_and_map();
    logic [7:0] v;
    set_time(8'hD9, 8'hA0, 8'h85, 8'hFF, 8'hDF, 8'hE3, 8'h12);
    read_time();
    check("R13 sec mask", tm[0], 8'h59); check("R13 min mask", tm[1], 8'h20);
    check("R13 hour mask", tm[2], 8'h05); check("R13 wday mask", tm[3], 8'h07);
    check("R13 date mask", tm[4], 8'h1F); check("R13 month mask", tm[5], 8'h83);
    check("R13 year full", tm[6], 8'h12);
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wreg(4'h8, 8'h55);
    rreg(4'h8, v); check("R2 unmapped reads zero", v, 8'h00);
    wreg(4'hE, 8'h7F);
    rreg(4'hE, v); check("R4 ctrl low bits read zero", v, 8'h00);
    load(4'hF); rbyte(v); rbyte(v);
    check("R2 pointer wraps F->0", v, 8'h00);
    wreg(4'h2, 8'h14);
    load(4'h1); rbyte(v); rbyte(v);
    check("R2 pointer steps to hour", v, 8'h14);
  endtask

  task automatic t_restop();
    logic [7:0] v;
    wreg(4'hE, 8'h80);
    rreg(4'hE, v); check("R4 stop bit set", v, 8'h80);
    rreg(4'hF, v); check("R5 fault set on stop", v, 8'h80);
    wreg(4'h0, 8'h05);
    rreg(4'hF, v); check("R5 no clear while stopped", v, 8'h80);
    ticks(2 * DIV);
    rreg(4'h0, v); check("R4 frozen while stopped", v, 8'h05);
    wreg(4'hE, 8'h00);
    wreg(4'h0, 8'h05);
    rreg(4'hF, v); check("R5 cleared after restart and write", v, 8'h00);
    ticks(DIV);
    rreg(4'h0, v); check("R6 runs again", v, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_stopped_ticks();
    t_fault_flag();
    t_phase_and_rollover();
    t_months();
    t_twelve_hour();
    t_snapshot();
    t_masks_and_map();
    t_restop();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule